// File: doc/BRIEF.md
# Mode-Banked Serial Port Register File

This block is the register file of a 16550-style serial controller. A host reaches it over a simple word-addressed bus, where the register index is the byte address shifted right by two. The value last written to the line control register picks one of three access banks: operational, configuration A or configuration B. Each bank maps a different set of registers onto the same indices. A few registers are reachable from every bank: the line control register, the mode definition register and the supplementary control register.

The block stores the baud divisor bytes, the enhanced feature register, the interrupt enable mask, the modem control register, the FIFO control settings, the transmission-control and trigger-level registers, the supplementary control register and the mode definition register. It drives the decoded settings to the baud generator and the FIFOs. It also turns accesses to the data index into push and pop strobes for the transmit and receive paths. Bit 4 of the enhanced feature register unlocks the upper interrupt-enable bits and the trigger-level submode.

Top module: `uart_regbank`

## Requirements
- R1: After reset, `acc_mode` is 0 (operational), `divisor` is 0, `baud_en` is 0, `fifo_en` is 0, index 3 reads 0x00 and index 8 reads 0x07.
- R2: A write to index 3 stores the line control value, and `acc_mode` follows it from the next cycle. The value 0xBF gives 2 (configuration B). Any other value with bit 7 set gives 1 (configuration A). A value with bit 7 clear gives 0 (operational).
- R3: In configuration B, index 0 is the divisor low byte and index 1 is the divisor high byte, and `divisor` = {high, low}. A divisor write is ignored unless the mode definition register holds 7.
- R4: In configuration B, index 2 reads and writes the enhanced feature register. In the other banks, a write to index 2 goes to the FIFO control register instead.
- R5: In the operational bank, index 1 is the interrupt enable register. Bits 3:0 are always written. Bits 7:4 change only while bit 4 of the enhanced feature register is 1.
- R6: In configuration A, index 4 is the modem control register. Its bit 6 changes only while bit 4 of the enhanced feature register is 1.
- R7: Index 6 maps the transmission-control register and index 7 maps the trigger-level register only in configuration A, with modem control bit 6 and enhanced bit 4 both set. Otherwise both indices are unmapped.
- R8: A FIFO control write sets `fifo_en` from bit 0, `rx_trig` from bits 7:6 and `tx_trig` from bits 5:4. Bit 1 raises `rx_fifo_clr` and bit 2 raises `tx_fifo_clr` for exactly the one cycle after the write edge. Index 2 reads 0 outside configuration B.
- R9: Index 8 (mode definition, 3 bits) and index 16 (supplementary control) are mapped in every bank. `baud_en` is 1 exactly when the mode definition register holds 0. `rx_gran1` equals supplementary bit 7.
- R10: Index 3 reads back the line control value in every bank. Its fields drive `char_len_sel` from bits 1:0, `stop_sel` from bit 2 and `parity_sel` from bits 5:3.
- R11: A read of an index unmapped in the current bank returns 0, and a write to it changes no register.
- R12: In the operational bank, index 0 is the data port. A read returns `rx_data` with `rx_rd` high in the same cycle. A write raises `tx_wr` in the same cycle, with `tx_data` equal to the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address; index is addr >> 2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| rx_data | input | 8 | Byte at the head of the receive path |
| rx_rd | output | 1 | Pop strobe for the receive path |
| tx_wr | output | 1 | Push strobe for the transmit path |
| tx_data | output | 8 | Byte pushed to the transmit path |
| acc_mode | output | 2 | Access bank: 0 operational, 1 config A, 2 config B |
| divisor | output | 16 | Baud divisor {high, low} |
| baud_en | output | 1 | Serial function on in 16x mode |
| char_len_sel | output | 2 | Character length minus 5 |
| stop_sel | output | 1 | Stop bits minus 1 |
| parity_sel | output | 3 | Parity field |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Receive trigger code |
| tx_trig | output | 2 | Transmit trigger code |
| rx_gran1 | output | 1 | Single-character receive trigger granularity |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| ier_q | output | 8 | Interrupt enable mask |
| mcr_q | output | 8 | Modem control register |
| tcr_q | output | 8 | Transmission-control register |
| tlr_q | output | 8 | Trigger-level register |

## Verification
Reads and the data-port strobes are combinational, so the bench samples `rdata`, `rx_rd` and `tx_wr` one nanosecond after it drives the bus, inside the same cycle. Every register write takes effect at the next rising edge. The bench therefore checks bank changes, stored values and decoded outputs at the falling edge that follows the write edge. The FIFO clear strobes are due in exactly that cycle and must be gone one cycle later, so the bench checks them at two falling edges in a row.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic [1:0] {
        MODE_OP    = 2'd0,
        MODE_CFG_A = 2'd1,
        MODE_CFG_B = 2'd2
    } acc_mode_e;

    localparam logic [7:0] LCR_CFG_B_KEY = 8'hBF;
    localparam logic [2:0] MDR_OFF       = 3'd7;
    localparam logic [2:0] MDR_16X       = 3'd0;
    localparam int         EFR_ENH_BIT   = 4;
    localparam int         MCR_SUB_BIT   = 6;

    localparam int IDX_DATA = 0;
    localparam int IDX_IER  = 1;
    localparam int IDX_FCR  = 2;
    localparam int IDX_LCR  = 3;
    localparam int IDX_MCR  = 4;
    localparam int IDX_TCR  = 6;
    localparam int IDX_TLR  = 7;
    localparam int IDX_MDR  = 8;
    localparam int IDX_SCR  = 16;

    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_trig;
        logic       en;
    } fifo_cfg_t;

    typedef struct packed {
        logic [7:0] dll;
        logic [7:0] dlm;
        logic [7:0] efr;
        logic [7:0] ier;
        logic [7:0] mcr;
        logic [7:0] tcr;
        logic [7:0] tlr;
        logic [7:0] scr;
        logic [2:0] mdr;
        fifo_cfg_t  fifo;
    } cfg_regs_t;

    function automatic acc_mode_e lcr_to_mode(input logic [7:0] v);
        if (v == LCR_CFG_B_KEY) return MODE_CFG_B;
        else if (v[7])          return MODE_CFG_A;
        else                    return MODE_OP;
    endfunction

    function automatic logic sub_bank_open(input acc_mode_e m, input cfg_regs_t r);
        return (m == MODE_CFG_A) && r.mcr[MCR_SUB_BIT] && r.efr[EFR_ENH_BIT];
    endfunction

endpackage

// File: rtl/uart_rf_lcr.sv
module uart_rf_lcr
    import uart_rf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       lcr_q,
    output acc_mode_e        mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q <= '0;
        end else if (wr_en && idx == IDX_W'(IDX_LCR)) begin
            lcr_q <= wdata;
        end
    end

    assign mode = lcr_to_mode(lcr_q);

endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
    import uart_rf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  acc_mode_e        mode,
    output cfg_regs_t        regs,
    output logic             rx_clr,
    output logic             tx_clr,
    output logic             tx_wr
);

    cfg_regs_t regs_q;
    logic      rx_clr_q, tx_clr_q;
    logic      enh_on, sub_open, div_open;
    logic      wr_dll, wr_dlm, wr_efr, wr_fcr, wr_ier, wr_mcr;
    logic      wr_tcr, wr_tlr, wr_mdr, wr_scr;

    always_comb begin
        enh_on   = regs_q.efr[EFR_ENH_BIT];
        sub_open = sub_bank_open(mode, regs_q);
        div_open = (regs_q.mdr == MDR_OFF);
        wr_dll   = wr_en && mode == MODE_CFG_B && idx == IDX_W'(IDX_DATA) && div_open;
        wr_dlm   = wr_en && mode == MODE_CFG_B && idx == IDX_W'(IDX_IER) && div_open;
        wr_efr   = wr_en && mode == MODE_CFG_B && idx == IDX_W'(IDX_FCR);
        wr_fcr   = wr_en && mode != MODE_CFG_B && idx == IDX_W'(IDX_FCR);
        wr_ier   = wr_en && mode == MODE_OP && idx == IDX_W'(IDX_IER);
        wr_mcr   = wr_en && mode == MODE_CFG_A && idx == IDX_W'(IDX_MCR);
        wr_tcr   = wr_en && sub_open && idx == IDX_W'(IDX_TCR);
        wr_tlr   = wr_en && sub_open && idx == IDX_W'(IDX_TLR);
        wr_mdr   = wr_en && idx == IDX_W'(IDX_MDR);
        wr_scr   = wr_en && idx == IDX_W'(IDX_SCR);
        tx_wr    = wr_en && mode == MODE_OP && idx == IDX_W'(IDX_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q     <= '0;
            regs_q.mdr <= MDR_OFF;
            rx_clr_q   <= 1'b0;
            tx_clr_q   <= 1'b0;
        end else begin
            if (wr_dll) regs_q.dll <= wdata;
            if (wr_dlm) regs_q.dlm <= wdata;
            if (wr_efr) regs_q.efr <= wdata;
            if (wr_ier) regs_q.ier <= enh_on ? wdata : {regs_q.ier[7:4], wdata[3:0]};
            if (wr_mcr) regs_q.mcr <= {wdata[7],
                                       enh_on ? wdata[MCR_SUB_BIT] : regs_q.mcr[MCR_SUB_BIT],
                                       wdata[5:0]};
            if (wr_tcr) regs_q.tcr <= wdata;
            if (wr_tlr) regs_q.tlr <= wdata;
            if (wr_mdr) regs_q.mdr <= wdata[2:0];
            if (wr_scr) regs_q.scr <= wdata;
            if (wr_fcr) regs_q.fifo <= '{rx_trig: wdata[7:6], tx_trig: wdata[5:4], en: wdata[0]};
            rx_clr_q <= wr_fcr && wdata[1];
            tx_clr_q <= wr_fcr && wdata[2];
        end
    end

    assign regs   = regs_q;
    assign rx_clr = rx_clr_q;
    assign tx_clr = tx_clr_q;

endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
    import uart_rf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  acc_mode_e        mode,
    input  cfg_regs_t        regs,
    input  logic [7:0]       lcr_q,
    input  logic [7:0]       rx_data,
    output logic [7:0]       rdata,
    output logic             rx_rd
);

    logic sub_open;

    always_comb begin
        sub_open = sub_bank_open(mode, regs);
        rdata    = '0;
        case (idx)
            IDX_W'(IDX_DATA): if (mode == MODE_OP) rdata = rx_data;
                              else if (mode == MODE_CFG_B) rdata = regs.dll;
            IDX_W'(IDX_IER):  if (mode == MODE_OP) rdata = regs.ier;
                              else if (mode == MODE_CFG_B) rdata = regs.dlm;
            IDX_W'(IDX_FCR):  if (mode == MODE_CFG_B) rdata = regs.efr;
            IDX_W'(IDX_LCR):  rdata = lcr_q;
            IDX_W'(IDX_MCR):  if (mode == MODE_CFG_A) rdata = regs.mcr;
            IDX_W'(IDX_TCR):  if (sub_open) rdata = regs.tcr;
            IDX_W'(IDX_TLR):  if (sub_open) rdata = regs.tlr;
            IDX_W'(IDX_MDR):  rdata = {5'd0, regs.mdr};
            IDX_W'(IDX_SCR):  rdata = regs.scr;
            default:          rdata = '0;
        endcase
        rx_rd = rd_en && mode == MODE_OP && idx == IDX_W'(IDX_DATA);
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int IDX_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        rx_data,
    output logic              rx_rd,
    output logic              tx_wr,
    output logic [7:0]        tx_data,
    output logic [1:0]        acc_mode,
    output logic [15:0]       divisor,
    output logic              baud_en,
    output logic [1:0]        char_len_sel,
    output logic              stop_sel,
    output logic [2:0]        parity_sel,
    output logic              fifo_en,
    output logic [1:0]        rx_trig,
    output logic [1:0]        tx_trig,
    output logic              rx_gran1,
    output logic              rx_fifo_clr,
    output logic              tx_fifo_clr,
    output logic [7:0]        ier_q,
    output logic [7:0]        mcr_q,
    output logic [7:0]        tcr_q,
    output logic [7:0]        tlr_q
);

    localparam int IDX_W = ADDR_W - IDX_SHIFT;

    logic [IDX_W-1:0] idx;
    logic             unused_low;
    logic [7:0]       lcr_q;
    acc_mode_e        mode;
    cfg_regs_t        regs;
    logic             efr_on_w;
    logic [2:0]       mdr_w;

    assign idx        = addr[ADDR_W-1:IDX_SHIFT];
    assign unused_low = ^addr[IDX_SHIFT-1:0];

    uart_rf_lcr #(.IDX_W(IDX_W)) u_lcr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
        .lcr_q(lcr_q), .mode(mode)
    );

    uart_rf_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
        .mode(mode), .regs(regs), .rx_clr(rx_fifo_clr), .tx_clr(tx_fifo_clr),
        .tx_wr(tx_wr)
    );

    uart_rf_rdmux #(.IDX_W(IDX_W)) u_rd (
        .rd_en(rd_en), .idx(idx), .mode(mode), .regs(regs), .lcr_q(lcr_q),
        .rx_data(rx_data), .rdata(rdata), .rx_rd(rx_rd)
    );

    assign efr_on_w     = regs.efr[EFR_ENH_BIT];
    assign mdr_w        = regs.mdr;
    assign tx_data      = wdata;
    assign acc_mode     = mode;
    assign divisor      = {regs.dlm, regs.dll};
    assign baud_en      = (regs.mdr == MDR_16X);
    assign char_len_sel = lcr_q[1:0];
    assign stop_sel     = lcr_q[2];
    assign parity_sel   = lcr_q[5:3];
    assign fifo_en      = regs.fifo.en;
    assign rx_trig      = regs.fifo.rx_trig;
    assign tx_trig      = regs.fifo.tx_trig;
    assign rx_gran1     = regs.scr[7];
    assign ier_q        = regs.ier;
    assign mcr_q        = regs.mcr;
    assign tcr_q        = regs.tcr;
    assign tlr_q        = regs.tlr;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] idx,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic [1:0]       acc_mode,
    input logic [15:0]      divisor,
    input logic [2:0]       mdr,
    input logic             efr_on,
    input logic [7:0]       ier_q,
    input logic             rx_fifo_clr,
    input logic             tx_wr
);

    // R2: the configuration-B key value opens bank B on the next cycle
    p_cfg_b_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDX_W'(3) && wdata == 8'hBF) |=> (acc_mode == 2'd2));

    // R3: divisor is frozen while the serial function is not disabled
    p_div_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (mdr != 3'd7) |=> $stable(divisor));

    // R5: upper interrupt-enable bits hold while enhanced control is off
    p_ier_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (!efr_on) |=> $stable(ier_q[7:4]));

    // R8: a receive-clear write yields the clear strobe on the next cycle
    p_rx_clr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDX_W'(2) && acc_mode != 2'd2 && wdata[1]) |=> rx_fifo_clr);

    // R11: index 5 is never mapped
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_W'(5)) |-> (rdata == 8'd0));

    // R12: the transmit strobe only comes from an operational data-port write
    p_tx_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> (wr_en && acc_mode == 2'd0 && idx == IDX_W'(0)));

endmodule

bind uart_regbank uart_regbank_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
    .rdata(rdata), .acc_mode(acc_mode), .divisor(divisor), .mdr(mdr_w),
    .efr_on(efr_on_w), .ier_q(ier_q), .rx_fifo_clr(rx_fifo_clr), .tx_wr(tx_wr)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/100ps
module sim_uart_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [7:0]  wdata = '0, rx_data = '0;
    logic [7:0]  rdata, tx_data, ier_q, mcr_q, tcr_q, tlr_q;
    logic        rx_rd, tx_wr, baud_en, stop_sel, fifo_en, rx_gran1;
    logic        rx_fifo_clr, tx_fifo_clr;
    logic [1:0]  acc_mode, char_len_sel, rx_trig, tx_trig;
    logic [2:0]  parity_sel;
    logic [15:0] divisor;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    uart_regbank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_rd(rx_rd),
        .tx_wr(tx_wr), .tx_data(tx_data), .acc_mode(acc_mode), .divisor(divisor),
        .baud_en(baud_en), .char_len_sel(char_len_sel), .stop_sel(stop_sel),
        .parity_sel(parity_sel), .fifo_en(fifo_en), .rx_trig(rx_trig),
        .tx_trig(tx_trig), .rx_gran1(rx_gran1), .rx_fifo_clr(rx_fifo_clr),
        .tx_fifo_clr(tx_fifo_clr), .ier_q(ier_q), .mcr_q(mcr_q), .tcr_q(tcr_q),
        .tlr_q(tlr_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // write: driven at a falling edge, committed at the next rising edge,
    // returns at the following falling edge where the new state is visible
    task automatic bus_wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        addr = 7'(idx << 2); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int idx, output logic [7:0] v, output logic strobe);
        @(negedge clk);
        addr = 7'(idx << 2) | 7'd1; rd_en = 1'b1;
        #1;
        v = rdata; strobe = rx_rd;
        #1 rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [7:0] exp);
        logic [7:0] v;
        logic s;
        bus_rd(idx, v, s);
        chk(req, $sformatf("read idx %0d", idx), v, exp);
    endtask

    task automatic t_reset;
        chk("R1", "acc_mode", acc_mode, 0);
        chk("R1", "divisor", divisor, 0);
        chk("R1", "baud_en", baud_en, 0);
        chk("R1", "fifo_en", fifo_en, 0);
        rd_chk("R1", 3, 8'h00);
        rd_chk("R1", 8, 8'h07);
    endtask

    task automatic t_modes;
        bus_wr(3, 8'h80); chk("R2", "mode after 0x80", acc_mode, 1);
        bus_wr(3, 8'hBF); chk("R2", "mode after 0xBF", acc_mode, 2);
        bus_wr(3, 8'h03); chk("R2", "mode after 0x03", acc_mode, 0);
        chk("R10", "char_len_sel", char_len_sel, 3);
        bus_wr(3, 8'h1F);
        chk("R10", "stop_sel", stop_sel, 1);
        chk("R10", "parity_sel", parity_sel, 3);
        rd_chk("R10", 3, 8'h1F);
        bus_wr(3, 8'h9F); chk("R2", "mode after 0x9F", acc_mode, 1);
        rd_chk("R10", 3, 8'h9F);
    endtask

    task automatic t_divisor;
        bus_wr(3, 8'hBF);
        bus_wr(0, 8'h34);
        bus_wr(1, 8'h12);
        chk("R3", "divisor", divisor, 16'h1234);
        rd_chk("R3", 0, 8'h34);
        bus_wr(8, 8'h00);
        chk("R9", "baud_en in 16x", baud_en, 1);
        bus_wr(0, 8'hFF);
        bus_wr(1, 8'hEE);
        chk("R3", "divisor locked", divisor, 16'h1234);
        bus_wr(8, 8'h07);
        chk("R9", "baud_en off", baud_en, 0);
    endtask

    task automatic t_efr_ier;
        bus_wr(3, 8'h00);
        bus_wr(1, 8'hF5);
        rd_chk("R5", 1, 8'h05);
        bus_wr(3, 8'hBF);
        rd_chk("R3", 1, 8'h12);
        bus_wr(2, 8'h10);
        rd_chk("R4", 2, 8'h10);
        chk("R4", "fifo_en untouched by EFR write", fifo_en, 0);
        bus_wr(3, 8'h00);
        bus_wr(1, 8'hF5);
        rd_chk("R5", 1, 8'hF5);
        chk("R5", "ier_q", ier_q, 8'hF5);
    endtask

    task automatic t_mcr_sub;
        bus_wr(3, 8'h80);
        bus_wr(4, 8'h43);
        rd_chk("R6", 4, 8'h43);
        bus_wr(6, 8'h5A);
        bus_wr(7, 8'hA5);
        rd_chk("R7", 6, 8'h5A);
        rd_chk("R7", 7, 8'hA5);
        chk("R7", "tcr_q", tcr_q, 8'h5A);
        chk("R7", "tlr_q", tlr_q, 8'hA5);
        bus_wr(3, 8'hBF);
        bus_wr(2, 8'h00);
        bus_wr(3, 8'h80);
        rd_chk("R7", 6, 8'h00);
        bus_wr(7, 8'h11);
        chk("R7", "tlr_q unchanged when closed", tlr_q, 8'hA5);
        bus_wr(4, 8'h00);
        rd_chk("R6", 4, 8'h40);
        chk("R6", "mcr_q", mcr_q, 8'h40);
    endtask

    task automatic t_fcr;
        bus_wr(3, 8'h03);
        bus_wr(2, 8'h63);
        chk("R8", "rx_fifo_clr pulse", rx_fifo_clr, 1);
        chk("R8", "tx_fifo_clr idle", tx_fifo_clr, 0);
        chk("R8", "fifo_en", fifo_en, 1);
        chk("R8", "rx_trig", rx_trig, 1);
        chk("R8", "tx_trig", tx_trig, 2);
        @(negedge clk);
        chk("R8", "rx_fifo_clr self-clear", rx_fifo_clr, 0);
        rd_chk("R8", 2, 8'h00);
        bus_wr(2, 8'h05);
        chk("R8", "tx_fifo_clr pulse", tx_fifo_clr, 1);
        chk("R8", "rx_fifo_clr idle", rx_fifo_clr, 0);
        chk("R8", "rx_trig cleared", rx_trig, 0);
        @(negedge clk);
        chk("R8", "tx_fifo_clr self-clear", tx_fifo_clr, 0);
    endtask

    task automatic t_scr_mdr;
        bus_wr(3, 8'h80);
        bus_wr(16, 8'h80);
        chk("R9", "rx_gran1", rx_gran1, 1);
        bus_wr(3, 8'hBF);
        rd_chk("R9", 16, 8'h80);
        rd_chk("R9", 8, 8'h07);
        bus_wr(3, 8'h00);
        bus_wr(8, 8'h00);
        rd_chk("R9", 8, 8'h00);
        chk("R9", "baud_en from op bank", baud_en, 1);
        bus_wr(8, 8'h07);
    endtask

    task automatic t_unmapped;
        bus_wr(3, 8'hBF);
        rd_chk("R11", 5, 8'h00);
        rd_chk("R11", 4, 8'h00);
        bus_wr(3, 8'h00);
        bus_wr(4, 8'hFF);
        bus_wr(3, 8'h80);
        rd_chk("R11", 4, 8'h40);
        rd_chk("R11", 0, 8'h00);
        bus_wr(0, 8'h77);
        chk("R11", "divisor after bank-A idx 0 write", divisor, 16'h1234);
    endtask

    task automatic t_data_port;
        logic [7:0] v;
        logic s;
        bus_wr(3, 8'h03);
        rx_data = 8'hC3;
        bus_rd(0, v, s);
        chk("R12", "rx read data", v, 8'hC3);
        chk("R12", "rx_rd strobe", s, 1);
        @(negedge clk);
        addr = 7'd0; wdata = 8'h5E; wr_en = 1'b1;
        #1;
        chk("R12", "tx_wr strobe", tx_wr, 1);
        chk("R12", "tx_data", tx_data, 8'h5E);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R12", "tx_wr idle", tx_wr, 0);
        chk("R12", "divisor unchanged", divisor, 16'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modes();
        t_divisor();
        t_efr_ier();
        t_mcr_sub();
        t_fcr();
        t_scr_mdr();
        t_unmapped();
        t_data_port();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule